// File: doc/BRIEF.md
# GPIO interrupt cause and mask unit

This unit turns the polarity-corrected input vector of a general-purpose I/O port into a small set of interrupt request lines. Each pin can raise an interrupt in two ways. The first is a level source, where the corrected input is gated by a level-enable bit. The second is an edge source, where a sticky pending bit is set by a rising transition of the corrected input and then gated by an edge-enable bit. The two gated sources of a pin are ORed together. The pins are then gathered in fixed groups, and each group drives one request line.

Software reaches the pending register and the two enable registers through a simple word-wide write port and a combinational read port. Pending bits are cleared by writing zeros to them. Writing ones has no effect, so a handler can acknowledge exactly the bits it has served. Edge sensing is active only on pins that the direction input marks as inputs. The pad synchronizer and any polarity inversion sit outside this unit.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset is held and right after it, the pending register and both enable registers read zero and every request line is low.
- R2: The pending register sits at byte address 0x14. The edge-enable register sits at 0x18 + MASK_OFS and the level-enable register at 0x1C + MASK_OFS. Both enable registers read back what was written. Any other address reads zero, and writes to it change nothing.
- R3: For every pin, a high corrected input whose level-enable bit is 1 drives that pin's group line high in the same cycle. When the level-enable bit is 0, the level source of that pin is ignored.
- R4: A 0-to-1 change of the corrected input on a pin whose direction bit is 1 (input) sets that pin's pending bit at the next clock edge. The bit stays set after the input falls again.
- R5: A 1-to-0 change, an input that stays high, and any change on a pin whose direction bit is 0 (output) all leave the pending bit unchanged.
- R6: A pending bit drives its group line only while its edge-enable bit is 1. Clearing the enable bit does not clear the pending bit.
- R7: A write to the pending register clears every bit whose write-data bit is 0 and leaves every bit whose write-data bit is 1 unchanged.
- R8: If a rising edge on a pin arrives in the same cycle as a write that clears that pin's pending bit, the bit ends up set.
- R9: Request line g is the OR of the causes of pins g*GROUP through g*GROUP+GROUP-1. With the default configuration, 32 pins form four groups of eight.
- R10: A pin that is already high when reset is released records no edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_level | input | PINS | Polarity-corrected pin inputs |
| pin_is_input | input | PINS | Direction per pin, 1 = input (edge sensing enabled) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address for read and write |
| reg_wdata | input | PINS | Write data |
| reg_rdata | output | PINS | Combinational read data for reg_addr |
| irq_group | output | PINS/GROUP | One request line per pin group |

## Verification
A software write that clears the pending register and a fresh rising edge on the same pin can land on the same clock edge. This is the race that decides whether an interrupt is lost. The bench provokes it by driving the clearing write and the new input transition on the same falling clock edge. It does this both for a pin whose bit was already pending and for a pin whose bit was clear. It then reads the pending register back and expects exactly the pins that saw the new edge. The checker also asserts, on every cycle, that a detected rise is never lost to a coincident write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Base byte offsets of the register window (mask registers add MASK_OFS)
   localparam int unsigned OFS_PEND  = 32'h14;
   localparam int unsigned OFS_EMASK = 32'h18;
   localparam int unsigned OFS_LMASK = 32'h1C;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_PEND  = 2'd1,
      SEL_EMASK = 2'd2,
      SEL_LMASK = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/gpio_irq_edge_det.sv
module gpio_irq_edge_det #(
   parameter int unsigned PINS = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] level_in,
   input  logic [PINS-1:0] sense_en,
   output logic [PINS-1:0] rise
);

   // Armed one cycle after reset so that pins already high are not seen as edges
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      logic prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= level_in[p];
      end

      assign rise[p] = armed_q & sense_en[p] & level_in[p] & ~prev_q;
   end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned PINS     = 32,
   parameter int unsigned AW       = 8,
   parameter int unsigned MASK_OFS = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [AW-1:0]   addr,
   input  logic [PINS-1:0] wdata,
   input  logic [PINS-1:0] rise,
   output logic [PINS-1:0] rdata,
   output logic [PINS-1:0] pend,
   output logic [PINS-1:0] emask,
   output logic [PINS-1:0] lmask
);

   localparam logic [AW-1:0] A_PEND  = AW'(OFS_PEND);
   localparam logic [AW-1:0] A_EMASK = AW'(OFS_EMASK + MASK_OFS);
   localparam logic [AW-1:0] A_LMASK = AW'(OFS_LMASK + MASK_OFS);

   reg_sel_e        sel;
   logic [PINS-1:0] pend_q, pend_d;
   logic [PINS-1:0] emask_q, lmask_q;

   always_comb begin
      if      (addr == A_PEND)  sel = SEL_PEND;
      else if (addr == A_EMASK) sel = SEL_EMASK;
      else if (addr == A_LMASK) sel = SEL_LMASK;
      else                      sel = SEL_NONE;
   end

   // Write-zero-to-clear; a rise in the same cycle always survives
   always_comb begin
      pend_d = pend_q;
      if (wr && sel == SEL_PEND) pend_d = pend_q & wdata;
      pend_d = pend_d | rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         emask_q <= '0;
         lmask_q <= '0;
      end else begin
         pend_q <= pend_d;
         if (wr && sel == SEL_EMASK) emask_q <= wdata;
         if (wr && sel == SEL_LMASK) lmask_q <= wdata;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_PEND:  rdata = pend_q;
         SEL_EMASK: rdata = emask_q;
         SEL_LMASK: rdata = lmask_q;
         default:   rdata = '0;
      endcase
   end

   assign pend  = pend_q;
   assign emask = emask_q;
   assign lmask = lmask_q;

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
   parameter int unsigned PINS  = 32,
   parameter int unsigned GROUP = 8,
   localparam int unsigned NGRP = PINS / GROUP
) (
   input  logic [PINS-1:0] level_in,
   input  logic [PINS-1:0] lmask,
   input  logic [PINS-1:0] pend,
   input  logic [PINS-1:0] emask,
   output logic [NGRP-1:0] irq
);

   logic [PINS-1:0] cause;

   for (genvar p = 0; p < PINS; p++) begin : g_cause
      assign cause[p] = (level_in[p] & lmask[p]) | (pend[p] & emask[p]);
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign irq[g] = |cause[g*GROUP +: GROUP];
   end

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
   parameter int unsigned PINS     = 32,
   parameter int unsigned GROUP    = 8,
   parameter int unsigned AW       = 8,
   parameter int unsigned MASK_OFS = 0,
   localparam int unsigned NGRP    = PINS / GROUP
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] pin_level,
   input  logic [PINS-1:0] pin_is_input,
   input  logic            reg_wr,
   input  logic [AW-1:0]   reg_addr,
   input  logic [PINS-1:0] reg_wdata,
   output logic [PINS-1:0] reg_rdata,
   output logic [NGRP-1:0] irq_group
);

   if (GROUP == 0 || PINS % GROUP != 0) begin : g_bad_group
      $error("PINS must be a nonzero multiple of GROUP");
   end
   if (PINS > 32 || PINS == 0) begin : g_bad_pins
      $error("PINS must be 1..32");
   end
   if (MASK_OFS % 4 != 0) begin : g_bad_ofs
      $error("MASK_OFS must be word aligned");
   end
   if (32'h1C + MASK_OFS >= (64'd1 << AW)) begin : g_bad_aw
      $error("AW too narrow for the register window");
   end

   logic [PINS-1:0] rise_w;
   logic [PINS-1:0] pend_w, emask_w, lmask_w;

   gpio_irq_edge_det #(.PINS(PINS)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (pin_level),
      .sense_en (pin_is_input),
      .rise     (rise_w)
   );

   gpio_irq_regs #(.PINS(PINS), .AW(AW), .MASK_OFS(MASK_OFS)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .rise  (rise_w),
      .rdata (reg_rdata),
      .pend  (pend_w),
      .emask (emask_w),
      .lmask (lmask_w)
   );

   gpio_irq_merge #(.PINS(PINS), .GROUP(GROUP)) u_merge (
      .level_in (pin_level),
      .lmask    (lmask_w),
      .pend     (pend_w),
      .emask    (emask_w),
      .irq      (irq_group)
   );

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
   parameter int unsigned PINS     = 32,
   parameter int unsigned GROUP    = 8,
   parameter int unsigned AW       = 8,
   parameter int unsigned MASK_OFS = 0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [PINS-1:0]       pin_level,
   input logic [PINS-1:0]       pin_is_input,
   input logic                  reg_wr,
   input logic [AW-1:0]         reg_addr,
   input logic [PINS-1:0]       reg_wdata,
   input logic [PINS-1:0]       pend,
   input logic [PINS-1:0]       emask,
   input logic [PINS-1:0]       lmask,
   input logic [PINS/GROUP-1:0] irq_group
);

   localparam logic [AW-1:0] A_PEND = AW'(32'h14);

   logic            armed_c;
   logic [PINS-1:0] prev_c;
   logic [PINS-1:0] rise_c;
   logic            clr_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_c <= 1'b0;
         prev_c  <= '0;
      end else begin
         armed_c <= 1'b1;
         prev_c  <= pin_level;
      end
   end

   assign rise_c = armed_c ? (pin_level & pin_is_input & ~prev_c) : '0;
   assign clr_wr = reg_wr && (reg_addr == A_PEND);

   AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_c != '0) |=> ((pend & $past(rise_c)) == $past(rise_c))); // R4

   AST_NO_STRAY_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      armed_c |=> ((pend & ~$past(pend) & ~$past(rise_c)) == '0)); // R5

   AST_CLEAR_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((pend & ~$past(reg_wdata) & ~$past(rise_c)) == '0)); // R7

   AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && rise_c != '0) |=> ((pend & $past(rise_c)) == $past(rise_c))); // R8

   for (genvar g = 0; g < PINS / GROUP; g++) begin : g_grp
      AST_LEVEL_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
         ((pin_level[g*GROUP +: GROUP] & lmask[g*GROUP +: GROUP]) != '0) |-> irq_group[g]); // R3
      AST_EDGE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
         ((pend[g*GROUP +: GROUP] & emask[g*GROUP +: GROUP]) != '0) |-> irq_group[g]); // R6
   end

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(
   .PINS(PINS), .GROUP(GROUP), .AW(AW), .MASK_OFS(MASK_OFS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pin_level    (pin_level),
   .pin_is_input (pin_is_input),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .pend         (pend_w),
   .emask        (emask_w),
   .lmask        (lmask_w),
   .irq_group    (irq_group)
);

// File: tb/tb_gpio_irq_unit.sv
module tb_gpio_irq_unit;

   localparam int unsigned PINS = 32;
   localparam int unsigned GROUP = 8;
   localparam int unsigned AW = 8;
   localparam int unsigned MOFS = 32'h40;
   localparam logic [7:0] A_PEND  = 8'h14;
   localparam logic [7:0] A_EMASK = 8'h58;
   localparam logic [7:0] A_LMASK = 8'h5C;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] pin_level, pin_is_input, reg_wdata, reg_rdata;
   logic        reg_wr;
   logic [7:0]  reg_addr;
   logic [3:0]  irq_group;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   gpio_irq_unit #(.PINS(PINS), .GROUP(GROUP), .AW(AW), .MASK_OFS(MOFS)) dut (
      .clk (clk), .rst_n (rst_n), .pin_level (pin_level), .pin_is_input (pin_is_input),
      .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata), .irq_group (irq_group)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   function automatic logic [31:0] grp_of(input int p);
      return 32'(1) << (p / GROUP);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      pin_level = '1; pin_is_input = '1;
      repeat (2) @(negedge clk);
      // R1: reset values
      rd_reg(A_PEND, v);  chk("R1 pend in reset", v, 0);
      rd_reg(A_EMASK, v); chk("R1 emask in reset", v, 0);
      rd_reg(A_LMASK, v); chk("R1 lmask in reset", v, 0);
      chk("R1 irq in reset", 32'(irq_group), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R10: pins high at release record nothing
      rd_reg(A_PEND, v); chk("R10 no edge at release", v, 0);
      chk("R1 irq after reset", 32'(irq_group), 0);
      @(negedge clk); pin_level = '0;

      // R2: register map
      wr_reg(A_EMASK, 32'hA5A5_0F0F);
      wr_reg(A_LMASK, 32'h1234_5678);
      rd_reg(A_EMASK, v); chk("R2 emask readback", v, 32'hA5A5_0F0F);
      rd_reg(A_LMASK, v); chk("R2 lmask readback", v, 32'h1234_5678);
      rd_reg(8'h18, v);   chk("R2 unmapped read", v, 0);
      wr_reg(8'h18, 32'hFFFF_FFFF);
      wr_reg(8'h1C, 32'hFFFF_FFFF);
      rd_reg(A_EMASK, v); chk("R2 stray write emask", v, 32'hA5A5_0F0F);
      rd_reg(A_LMASK, v); chk("R2 stray write lmask", v, 32'h1234_5678);
      rd_reg(A_PEND, v);  chk("R2 stray write pend", v, 0);

      // R3, R9: level sweep with edge sensing off
      pin_is_input = '0;
      wr_reg(A_EMASK, 0);
      wr_reg(A_LMASK, '1);
      for (int p = 0; p < 32; p++) begin
         @(negedge clk); pin_level = 32'(1) << p;
         #1 chk($sformatf("R3 R9 level pin %0d", p), 32'(irq_group), grp_of(p));
      end
      for (int p = 0; p < 32; p++) begin
         wr_reg(A_LMASK, 32'(1) << p);
         pin_level = ~(32'(1) << p);
         #1 chk($sformatf("R3 masked pins %0d", p), 32'(irq_group), 0);
         pin_level = '1;
         #1 chk($sformatf("R3 R9 lone enable %0d", p), 32'(irq_group), grp_of(p));
      end
      @(negedge clk); pin_level = '0;
      wr_reg(A_LMASK, 0);

      // R4, R6, R7: edge sweep
      pin_is_input = '1;
      wr_reg(A_EMASK, '1);
      wr_reg(A_PEND, 0);
      for (int p = 0; p < 32; p++) begin
         @(negedge clk); pin_level = 32'(1) << p;
         rd_reg(A_PEND, v);
         chk($sformatf("R4 edge pin %0d", p), v, 32'(1) << p);
         chk($sformatf("R6 R9 edge irq pin %0d", p), 32'(irq_group), grp_of(p));
         @(negedge clk); pin_level = '0;
         repeat (2) @(negedge clk);
         rd_reg(A_PEND, v);
         chk($sformatf("R4 sticky pin %0d", p), v, 32'(1) << p);
         wr_reg(A_PEND, 0);
         rd_reg(A_PEND, v);
         chk($sformatf("R7 clear pin %0d", p), v, 0);
      end

      // R5: held high, falling, outputs
      @(negedge clk); pin_level = '1;
      wr_reg(A_PEND, 0);
      rd_reg(A_PEND, v); chk("R5 held high", v, 0);
      @(negedge clk); pin_level = '0;
      repeat (2) @(negedge clk);
      rd_reg(A_PEND, v); chk("R5 falling ignored", v, 0);
      pin_is_input = 32'h0000_FFFF;
      @(negedge clk); pin_level = '1;
      rd_reg(A_PEND, v); chk("R5 output pins ignored", v, 32'h0000_FFFF);

      // R6: edge enable gating
      wr_reg(A_EMASK, 32'h0000_FF00);
      #1 chk("R6 group1 only", 32'(irq_group), 32'h2);
      wr_reg(A_EMASK, 0);
      #1 chk("R6 all disabled", 32'(irq_group), 0);
      rd_reg(A_PEND, v); chk("R6 pend kept", v, 32'h0000_FFFF);

      // R7: partial clear and write-one no-op
      pin_is_input = '1;
      @(negedge clk); pin_level = '0;
      @(negedge clk); pin_level = '1;
      rd_reg(A_PEND, v); chk("R4 all pins", v, '1);
      wr_reg(A_PEND, 32'hFFFF_0000);
      rd_reg(A_PEND, v); chk("R7 partial clear", v, 32'hFFFF_0000);
      wr_reg(A_PEND, 32'hFFFF_FFFF);
      rd_reg(A_PEND, v); chk("R7 write ones no-op", v, 32'hFFFF_0000);

      // R8: clearing write collides with new edges (bit 16 pending, bit 3 not)
      @(negedge clk); pin_level = '0;
      repeat (2) @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_PEND; reg_wdata = 0;
      pin_level = 32'h0001_0008;
      @(negedge clk); reg_wr = 1'b0;
      rd_reg(A_PEND, v); chk("R8 edge beats clear", v, 32'h0001_0008);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule